// File: doc/BRIEF.md
# Four-Channel DAC Code and Power Sequencer

This block is the digital core of a four-channel voltage-output converter. Each cycle it may accept one already-deserialised 24-bit command word: a 4-bit operation in bits 23:20, a 4-bit channel selector in bits 19:16 and a 16-bit data word in bits 15:0. Every channel holds two registers. A staging register receives new codes. A live register drives the converter and changes only when an update operation copies the staging value into it.

The block also tracks whether each channel is powered. Any operation that includes an update switches its target channels on. A power-down operation switches them off and leaves every stored code as it is. When every channel is off, the shared bias is off as well. A channel that wakes up reports a busy flag while its output settles. The settle time is long if the bias had to restart, because all four channels were off before the command, and short otherwise. Both times are converted to clock cycles from a clock-frequency parameter.

For resolutions below 16 bits (parameter `RES_W`), the code is taken left-justified from the data word and the low bits are ignored. The analog stage, the reference and the serial front end sit outside this block.

Top module: `qdac_core`

## Requirements
- R1: Operation 0000 loads the data word into the staging register of the selected channel. No live code and no power state changes.
- R2: Operation 0001 copies the staging register of the selected channel into its live code and powers that channel on. The result is visible at `dac_code` after the accepting clock edge.
- R3: Operation 0010 loads the data word into the selected channel's staging register and, on the same edge, copies the staging register into the live code of all four channels, powering all of them on. The selected channel receives the new data word.
- R4: Operation 0011 loads the data word into the selected channel and makes it that channel's live code on the same edge, powering the channel on.
- R5: Operation 0100 powers off the selected channel. Its data word is ignored, and the staging and live registers of every channel keep their contents.
- R6: Channel codes 0000, 0001, 0010 and 0011 select channels A, B, C and D. Channel A is `dac_code[RES_W-1:0]` and `pwr_en[0]`, and the following channels occupy the higher slices in order. Channel code 1111 selects all four channels.
- R7: Operation 1111, any other operation code, and any channel code other than those in R6 leave all state and outputs unchanged.
- R8: `bias_en` is high exactly when at least one bit of `pwr_en` is high.
- R9: If all channels were off when an update is accepted, each channel it powers on holds its `busy` bit high for LONG_CYC cycles (600 at 50 MHz with a 12 µs setting).
- R10: If at least one channel was on when an update is accepted, each channel it powers on holds `busy` high for SHORT_CYC cycles (250 at 50 MHz with a 5 µs setting).
- R11: An update of a channel that is already on does not raise its `busy` bit. A power-down clears the target channel's `busy` bit on the accepting edge.
- R12: After reset, all codes are zero, all channels are off, `bias_en` is low and `busy` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Accept `cmd_word` on this edge |
| cmd_word | input | 24 | Operation [23:20], channel [19:16], data [15:0] |
| dac_code | output | 4*RES_W | Live codes, channel A in the lowest slice |
| pwr_en | output | 4 | Per-channel power enable |
| bias_en | output | 1 | Shared bias enable |
| busy | output | 4 | Per-channel settling in progress |

## Verification
A corrupted staging register stays hidden until the next update of that channel. At that point the wrong code appears at `dac_code` one edge after the update is accepted. For this reason the vectors write codes, power channels down and back up, and then update, so that stored values pass through to the outputs. A wrong power or delay-selection state appears as a `busy` window of the wrong length. The bench therefore samples `busy` on the last cycle of each window and on the cycle after it, so an off-by-one count or a long/short mix-up is caught within one cycle.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int NCH    = 4;
    localparam int WORD_W = 24;
    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        OP_STAGE        = 4'b0000,
        OP_COMMIT       = 4'b0001,
        OP_STAGE_ALLCOM = 4'b0010,
        OP_STAGE_COMMIT = 4'b0011,
        OP_SLEEP        = 4'b0100,
        OP_IDLE         = 4'b1111
    } op_e;

    localparam logic [3:0] SEL_ALL = 4'b1111;

    typedef struct packed {
        logic [NCH-1:0]    stage;
        logic [NCH-1:0]    commit;
        logic [NCH-1:0]    sleep;
        logic [DATA_W-1:0] data;
    } dec_t;

endpackage

// File: rtl/qdac_decode.sv
module qdac_decode
    import qdac_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    logic [3:0]     op;
    logic [3:0]     sel;
    logic [NCH-1:0] mask;
    logic           sel_ok;

    assign op  = word[23:20];
    assign sel = word[19:16];

    always_comb begin
        mask   = '0;
        sel_ok = 1'b1;
        if (sel == SEL_ALL) begin
            mask = '1;
        end else if (sel < 4'(NCH)) begin
            mask[sel[1:0]] = 1'b1;
        end else begin
            sel_ok = 1'b0;
        end
    end

    always_comb begin
        dec.stage  = '0;
        dec.commit = '0;
        dec.sleep  = '0;
        dec.data   = word[DATA_W-1:0];
        if (valid && sel_ok) begin
            unique case (op)
                OP_STAGE: begin
                    dec.stage = mask;
                end
                OP_COMMIT: begin
                    dec.commit = mask;
                end
                OP_STAGE_ALLCOM: begin
                    dec.stage  = mask;
                    dec.commit = '1;
                end
                OP_STAGE_COMMIT: begin
                    dec.stage  = mask;
                    dec.commit = mask;
                end
                OP_SLEEP: begin
                    dec.sleep = mask;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stage,
    input  logic             commit,
    input  logic             sleep,
    input  logic [RES_W-1:0] data,
    output logic [RES_W-1:0] code,
    output logic             on
);
    typedef struct packed {
        logic [RES_W-1:0] stg;
        logic [RES_W-1:0] live;
        logic             on;
    } ch_t;

    ch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stage) begin
            st_d.stg = data;
        end
        if (commit) begin
            st_d.live = stage ? data : st_q.stg;
            st_d.on   = 1'b1;
        end else if (sleep) begin
            st_d.on = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.live;
    assign on   = st_q.on;
endmodule

// File: rtl/qdac_settle.sv
module qdac_settle #(
    parameter int NCH       = 4,
    parameter int SHORT_CYC = 250,
    parameter int LONG_CYC  = 600
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] commit,
    input  logic [NCH-1:0] sleep,
    input  logic [NCH-1:0] on_now,
    output logic [NCH-1:0] busy
);
    localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [NCH-1:0][CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic cold;

    assign cold = (on_now == '0);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCH; i++) begin
            if (sleep[i]) begin
                st_d.cnt[i] = '0;
            end else if (commit[i] && !on_now[i]) begin
                st_d.cnt[i] = cold ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
            end else if (st_q.cnt[i] != '0) begin
                st_d.cnt[i] = st_q.cnt[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            busy[i] = (st_q.cnt[i] != '0);
        end
    end
endmodule

// File: rtl/qdac_core.sv
module qdac_core
    import qdac_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned SHORT_NS = 5_000,
    parameter int unsigned LONG_NS  = 12_000,
    parameter int          RES_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [23:0]          cmd_word,
    output logic [4*RES_W-1:0]   dac_code,
    output logic [3:0]           pwr_en,
    output logic                 bias_en,
    output logic [3:0]           busy
);
    localparam longint unsigned NS_PER_S = 64'd1_000_000_000;
    localparam longint unsigned SHORT_L  =
        (64'(CLK_HZ) * 64'(SHORT_NS) + NS_PER_S - 1) / NS_PER_S;
    localparam longint unsigned LONG_L   =
        (64'(CLK_HZ) * 64'(LONG_NS) + NS_PER_S - 1) / NS_PER_S;
    localparam int SHORT_CYC = (SHORT_L < 1) ? 1 : int'(SHORT_L);
    localparam int LONG_CYC  = (LONG_L < 1) ? 1 : int'(LONG_L);

    dec_t             dec;
    logic [NCH-1:0]   on_vec;
    logic [RES_W-1:0] code_in;

    qdac_decode u_dec (
        .valid (cmd_valid),
        .word  (cmd_word),
        .dec   (dec)
    );

    assign code_in = dec.data[DATA_W-1 -: RES_W];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        qdac_channel #(.RES_W(RES_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .stage  (dec.stage[g]),
            .commit (dec.commit[g]),
            .sleep  (dec.sleep[g]),
            .data   (code_in),
            .code   (dac_code[g*RES_W +: RES_W]),
            .on     (on_vec[g])
        );
    end

    qdac_settle #(
        .NCH       (NCH),
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (dec.commit),
        .sleep  (dec.sleep),
        .on_now (on_vec),
        .busy   (busy)
    );

    assign pwr_en  = on_vec;
    assign bias_en = |on_vec;
endmodule

// File: rtl/qdac_core_chk.sv
module qdac_core_chk #(
    parameter int RES_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [23:0]        cmd_word,
    input logic [4*RES_W-1:0] dac_code,
    input logic [3:0]         pwr_en,
    input logic               bias_en,
    input logic [3:0]         busy
);
    logic [3:0] op;
    logic [3:0] sel;
    logic       sel_ok;
    logic       op_known;

    assign op       = cmd_word[23:20];
    assign sel      = cmd_word[19:16];
    assign sel_ok   = (sel <= 4'd3) || (sel == 4'hF);
    assign op_known = (op <= 4'd4);

    // R11
    busy_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy & ~pwr_en) == 4'b0000);

    // R8
    bias_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bias_en == (pwr_en != 4'b0000));

    // R5
    sleep_keeps_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == 4'd4 && sel_ok) |=> $stable(dac_code));

    // R7
    ignored_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (!op_known || !sel_ok)) |=> ($stable(dac_code) && $stable(pwr_en)));

    // R1
    stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == 4'd0) |=> ($stable(dac_code) && $stable(pwr_en)));

    // R4
    stage_commit_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == 4'd3 && sel == 4'd0) |=>
        (dac_code[RES_W-1:0] == $past(cmd_word[15 -: RES_W]) && pwr_en[0]));
endmodule

bind qdac_core qdac_core_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .dac_code  (dac_code),
    .pwr_en    (pwr_en),
    .bias_en   (bias_en),
    .busy      (busy)
);

// File: tb/qdac_core_bench.sv
module qdac_core_bench;
    localparam int SHORT_CYC = 250;
    localparam int LONG_CYC  = 600;
    localparam int NV        = 13;

    localparam logic [23:0] V_WORD [NV] = '{
        24'h0_0_1234, 24'h1_0_0000, 24'h0_1_5678, 24'h3_2_9ABC,
        24'h4_0_FFFF, 24'h2_3_1111, 24'h5_0_0000, 24'h3_7_2222,
        24'hF_0_3333, 24'h4_F_0000, 24'h3_F_4444, 24'h0_1_7777,
        24'h1_F_0000
    };
    localparam logic [63:0] V_DAC [NV] = '{
        64'h0000_0000_0000_0000, 64'h0000_0000_0000_1234,
        64'h0000_0000_0000_1234, 64'h0000_9ABC_0000_1234,
        64'h0000_9ABC_0000_1234, 64'h1111_9ABC_5678_1234,
        64'h1111_9ABC_5678_1234, 64'h1111_9ABC_5678_1234,
        64'h1111_9ABC_5678_1234, 64'h1111_9ABC_5678_1234,
        64'h4444_4444_4444_4444, 64'h4444_4444_4444_4444,
        64'h4444_4444_7777_4444
    };
    localparam logic [3:0] V_PWR [NV] = '{
        4'b0000, 4'b0001, 4'b0001, 4'b0101, 4'b0100, 4'b1111, 4'b1111,
        4'b1111, 4'b1111, 4'b0000, 4'b1111, 4'b1111, 4'b1111
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [23:0] cmd_word = '0;
    logic [63:0] dac_code;
    logic [3:0]  pwr_en;
    logic        bias_en;
    logic [3:0]  busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    qdac_core u_qdac_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .dac_code  (dac_code),
        .pwr_en    (pwr_en),
        .bias_en   (bias_en),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [23:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150_000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R12 reset state
        chk(dac_code == '0, "R12 code", dac_code, 64'h0);
        chk(pwr_en == 4'b0, "R12 power", 64'(pwr_en), 64'h0);
        chk(!bias_en, "R12 bias", 64'(bias_en), 64'h0);
        chk(busy == 4'b0, "R12 busy", 64'(busy), 64'h0);

        // Vector walk covering R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            apply(V_WORD[i]);
            chk(dac_code == V_DAC[i], $sformatf("R1/R2/R3/R4/R5/R6/R7 code vec %0d", i),
                dac_code, V_DAC[i]);
            chk(pwr_en == V_PWR[i], $sformatf("R5 R6 power vec %0d", i),
                64'(pwr_en), 64'(V_PWR[i]));
            chk(bias_en == (V_PWR[i] != 0), $sformatf("R8 bias vec %0d", i),
                64'(bias_en), 64'(V_PWR[i] != 0));
        end

        // R9 long settle from all-off
        do_reset();
        apply(24'h3_0_ABCD);
        chk(busy == 4'b0001, "R9 busy start", 64'(busy), 64'h1);
        repeat (LONG_CYC - 1) @(negedge clk);
        chk(busy[0] == 1'b1, "R9 busy last cycle", 64'(busy), 64'h1);
        @(negedge clk);
        chk(busy[0] == 1'b0, "R9 busy end", 64'(busy), 64'h0);

        // R10 short settle when another channel is on
        apply(24'h3_1_0001);
        chk(busy == 4'b0010, "R10 busy start", 64'(busy), 64'h2);
        repeat (SHORT_CYC - 1) @(negedge clk);
        chk(busy[1] == 1'b1, "R10 busy last cycle", 64'(busy), 64'h2);
        @(negedge clk);
        chk(busy[1] == 1'b0, "R10 busy end", 64'(busy), 64'h0);

        // R11 update of a powered channel raises no busy
        apply(24'h1_0_0000);
        chk(busy == 4'b0000, "R11 no busy on powered", 64'(busy), 64'h0);
        chk(dac_code[15:0] == 16'hABCD, "R2 recommit keeps code",
            64'(dac_code[15:0]), 64'hABCD);

        // R11 power-down cancels settle
        apply(24'h3_2_0042);
        chk(busy == 4'b0100, "R11 busy set", 64'(busy), 64'h4);
        repeat (5) @(negedge clk);
        apply(24'h4_2_0000);
        chk(busy == 4'b0000, "R11 sleep clears busy", 64'(busy), 64'h0);
        chk(pwr_en == 4'b0011, "R5 sleep power", 64'(pwr_en), 64'h3);

        // R9 all channels from all-off take the long window
        apply(24'h4_F_0000);
        chk(!bias_en, "R8 bias off", 64'(bias_en), 64'h0);
        apply(24'h2_3_5555);
        chk(busy == 4'b1111, "R9 all busy", 64'(busy), 64'hF);
        chk(dac_code == 64'h5555_0042_0001_ABCD, "R3 R5 codes survive sleep",
            dac_code, 64'h5555_0042_0001_ABCD);
        repeat (LONG_CYC - 1) @(negedge clk);
        chk(busy == 4'b1111, "R9 all busy last", 64'(busy), 64'hF);
        @(negedge clk);
        chk(busy == 4'b0000, "R9 all busy end", 64'(busy), 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule